// File: doc/BRIEF.md
# SIMD Global Condition and Masking Unit

This unit sits between a scalar sequencer and an array of processing lanes that all execute one broadcast instruction stream. Every lane offers a local condition bit each cycle. The unit folds these bits into two global flags. One is true when every participating lane holds a true condition. The other is true when at least one participating lane does. The sequencer uses these flags for branches, either alone or gated by its own integer condition.

The unit also holds a per-lane activity mask for predicated regions. A lane whose mask bit is low turns every broadcast instruction into a no-op. Predicated regions may nest. On entry to a region, each lane saves its current mask on a stack shared in depth by all lanes. The region's alternate branch and its exit rebuild the mask from that saved copy. Branches never alter the mask, and the mask alters the flags only by choosing which lanes take part.

Top module: `simd_pred_unit`

## Requirements
- R1: `all_o` is registered. One clock edge after sampling, it equals the AND of `cond_i` over the lanes whose mask bit was set before that edge. Any mask update at the same edge does not affect it.
- R2: `any_o` is registered in the same way. It is the OR of `cond_i` over the lanes whose mask bit was set before the edge.
- R3: When no lane is active at the sampling edge, `all_o` reads 1 and `any_o` reads 0.
- R4: `br_all_o` and `br_any_o` update at the same edge as the global flags. They equal the AND-flag and the OR-flag, each ANDed with `scalar_cond_i` sampled at that edge.
- R5: Op code 1 (enter region) saves the mask on the stack, replaces the mask with mask AND `cond_i`, and raises `depth_o` by one.
- R6: Op code 2 (alternate branch) with a non-empty stack sets the mask to the top saved mask AND NOT `cond_i`. It leaves the stack and `depth_o` unchanged.
- R7: Op code 3 (leave region) with a non-empty stack restores the top saved mask and lowers `depth_o` by one.
- R8: Op code 1 issued when `depth_o` equals the stack depth (default 8) sets a sticky `overflow_o`. The mask and depth stay unchanged.
- R9: Op code 3 or op code 2 issued when `depth_o` is 0 sets a sticky `underflow_o`. The mask and depth stay unchanged.
- R10: While `rst_ni` is low, the mask is all ones, `depth_o` is 0, both error flags are clear, `all_o` and `br_all_o` are 1, and `any_o` and `br_any_o` are 0.
- R11: When `op_valid_i` is low, or the op code is 0 (no-op), the mask, the depth and the error flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cond_i | input | NUM_LANES | Local condition bit from each lane |
| op_valid_i | input | 1 | Qualifies op_i |
| op_i | input | 2 | 0 no-op, 1 enter region, 2 alternate branch, 3 leave region |
| scalar_cond_i | input | 1 | Sequencer integer condition |
| mask_o | output | NUM_LANES | Current per-lane activity mask |
| depth_o | output | clog2(STACK_DEPTH+1) | Number of saved masks |
| all_o | output | 1 | Registered AND over active lanes |
| any_o | output | 1 | Registered OR over active lanes |
| br_all_o | output | 1 | all_o gated by scalar condition |
| br_any_o | output | 1 | any_o gated by scalar condition |
| overflow_o | output | 1 | Sticky push-when-full flag |
| underflow_o | output | 1 | Sticky pop-or-else-when-empty flag |

## Verification
A corrupted saved mask stays hidden while the region is open. It appears on `mask_o` in the cycle after the alternate branch or the region exit reads it back. It then disturbs the global flags one edge later. A wrong depth shows at once on `depth_o`. It also shifts overflow or underflow to the wrong op, so nested fill-and-drain runs and random op streams compare every output against a queue model on every cycle. An all-false region is entered on purpose so that the empty-participant values of the flags are observed.

// File: rtl/simd_pred_pkg.sv
package simd_pred_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_PUSH = 2'd1,
    OP_ELSE = 2'd2,
    OP_POP  = 2'd3
  } pred_op_e;
endpackage

// File: rtl/simd_cond_reduce.sv
module simd_cond_reduce #(
  parameter int WIDTH = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] cond_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic             scalar_i,
  output logic             all_o,
  output logic             any_o,
  output logic             br_all_o,
  output logic             br_any_o
);
  localparam int LVLS   = (WIDTH > 1) ? $clog2(WIDTH) : 0;
  localparam int LEAVES = 1 << LVLS;

  logic [LEAVES-1:0] and_lf, or_lf;
  logic [LEAVES-1:0] and_t, or_t;

  // inactive and pad lanes are neutral for both reductions
  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < WIDTH) begin : g_real
      assign and_lf[k] = cond_i[k] | ~mask_i[k];
      assign or_lf[k]  = cond_i[k] & mask_i[k];
    end else begin : g_pad
      assign and_lf[k] = 1'b1;
      assign or_lf[k]  = 1'b0;
    end
  end

  always_comb begin
    and_t = and_lf;
    or_t  = or_lf;
    for (int l = 0; l < LVLS; l++) begin
      for (int i = 0; i < (LEAVES >> (l + 1)); i++) begin
        and_t[i] = and_t[2*i] & and_t[2*i+1];
        or_t[i]  = or_t[2*i]  | or_t[2*i+1];
      end
    end
  end

  logic all_q, any_q, br_all_q, br_any_q, primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      all_q    <= 1'b1;
      any_q    <= 1'b0;
      br_all_q <= 1'b1;
      br_any_q <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      all_q    <= and_t[0];
      any_q    <= or_t[0];
      br_all_q <= and_t[0] & scalar_i;
      br_any_q <= or_t[0] & scalar_i;
      primed_q <= 1'b1;
    end
  end

  assign all_o    = all_q;
  assign any_o    = any_q;
  assign br_all_o = br_all_q;
  assign br_any_o = br_any_q;

  assert_idle_flags_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && all_q && !any_q) |-> ($past(mask_i) == '0 || $past(cond_i & mask_i) == '0));
  assert_any_needs_lane_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && any_q) |-> ($past(mask_i) != '0));
  assert_br_all_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_all_q |-> all_q);
  assert_br_any_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_any_q |-> any_q);
endmodule

// File: rtl/simd_mask_stack.sv
module simd_mask_stack
  import simd_pred_pkg::*;
#(
  parameter int LANES = 128,
  parameter int DEPTH = 8,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  pred_op_e         op_i,
  input  logic [LANES-1:0] cond_i,
  output logic [LANES-1:0] mask_o,
  output logic [DW-1:0]    depth_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LANES-1:0] save_mem [DEPTH];
  logic [LANES-1:0] mask_q, top_w;
  logic [DW-1:0]    depth_q;
  logic             ovf_q, unf_q;
  logic             full_w, empty_w;
  logic [PW-1:0]    wr_idx, top_idx;
  logic             do_push, do_else, do_pop, bad_push, bad_pop;

  assign full_w  = (depth_q == DW'(DEPTH));
  assign empty_w = (depth_q == '0);
  assign wr_idx  = PW'(depth_q);
  assign top_idx = PW'(depth_q - 1'b1);
  assign top_w   = save_mem[top_idx];

  assign do_push  = op_valid_i && (op_i == OP_PUSH) && !full_w;
  assign bad_push = op_valid_i && (op_i == OP_PUSH) && full_w;
  assign do_else  = op_valid_i && (op_i == OP_ELSE) && !empty_w;
  assign do_pop   = op_valid_i && (op_i == OP_POP)  && !empty_w;
  assign bad_pop  = op_valid_i && (op_i == OP_POP || op_i == OP_ELSE) && empty_w;

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (do_push && wr_idx == PW'(e)) save_mem[e] <= mask_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '1;
      depth_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      if (do_push) begin
        mask_q  <= mask_q & cond_i;
        depth_q <= depth_q + 1'b1;
      end else if (do_else) begin
        mask_q  <= top_w & ~cond_i;
      end else if (do_pop) begin
        mask_q  <= top_w;
        depth_q <= depth_q - 1'b1;
      end
      if (bad_push) ovf_q <= 1'b1;
      if (bad_pop)  unf_q <= 1'b1;
    end
  end

  assign mask_o      = mask_q;
  assign depth_o     = depth_q;
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;

  assert_depth_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_q <= DW'(DEPTH));
  assert_push_narrows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_PUSH && depth_q < DW'(DEPTH)) |=>
      ((mask_q & ~$past(mask_q)) == '0 && depth_q == $past(depth_q) + DW'(1)));
  assert_else_keeps_depth_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_ELSE) |=> $stable(depth_q));
  assert_pop_depth_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_POP && depth_q != '0) |=> depth_q == $past(depth_q) - DW'(1));
  assert_push_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_PUSH && depth_q == DW'(DEPTH)) |=>
      (ovf_q && $stable(depth_q) && $stable(mask_q)));
  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  assert_pop_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (op_i == OP_POP || op_i == OP_ELSE) && depth_q == '0) |=>
      (unf_q && $stable(mask_q) && $stable(depth_q)));
  assert_unf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_q |=> unf_q);
  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i || op_i == OP_NOP) |=>
      ($stable(mask_q) && $stable(depth_q) && $stable(ovf_q) && $stable(unf_q)));
endmodule

// File: rtl/simd_pred_unit.sv
module simd_pred_unit
  import simd_pred_pkg::*;
#(
  parameter int NUM_LANES   = 128,
  parameter int STACK_DEPTH = 8,
  localparam int DW         = $clog2(STACK_DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LANES-1:0] cond_i,
  input  logic                 op_valid_i,
  input  logic [1:0]           op_i,
  input  logic                 scalar_cond_i,
  output logic [NUM_LANES-1:0] mask_o,
  output logic [DW-1:0]        depth_o,
  output logic                 all_o,
  output logic                 any_o,
  output logic                 br_all_o,
  output logic                 br_any_o,
  output logic                 overflow_o,
  output logic                 underflow_o
);
  logic [NUM_LANES-1:0] mask_w;
  pred_op_e             op_w;

  assign op_w = pred_op_e'(op_i);

  simd_mask_stack #(
    .LANES (NUM_LANES),
    .DEPTH (STACK_DEPTH)
  ) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_valid_i  (op_valid_i),
    .op_i        (op_w),
    .cond_i      (cond_i),
    .mask_o      (mask_w),
    .depth_o     (depth_o),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o)
  );

  simd_cond_reduce #(
    .WIDTH (NUM_LANES)
  ) u_reduce (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cond_i   (cond_i),
    .mask_i   (mask_w),
    .scalar_i (scalar_cond_i),
    .all_o    (all_o),
    .any_o    (any_o),
    .br_all_o (br_all_o),
    .br_any_o (br_any_o)
  );

  assign mask_o = mask_w;

  assert_mask_stable_when_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i) |=> $stable(mask_o));
endmodule

// File: tb/simd_pred_unit_bench.sv
module simd_pred_unit_bench;
  localparam int N  = 128;
  localparam int D  = 8;
  localparam int DW = $clog2(D + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  cond_i = '0;
  logic          op_valid_i = 1'b0;
  logic [1:0]    op_i = 2'd0;
  logic          scalar_cond_i = 1'b0;
  logic [N-1:0]  mask_o;
  logic [DW-1:0] depth_o;
  logic          all_o, any_o, br_all_o, br_any_o, overflow_o, underflow_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  simd_pred_unit u_simd_pred_unit (
    .clk_i, .rst_ni, .cond_i, .op_valid_i, .op_i, .scalar_cond_i,
    .mask_o, .depth_o, .all_o, .any_o, .br_all_o, .br_any_o,
    .overflow_o, .underflow_o
  );

  // behavioural reference
  logic [N-1:0] m_stk[$];
  logic [N-1:0] m_mask;
  bit m_all, m_any, m_ball, m_bany, m_ovf, m_unf, m_noact;
  string m_tag;

  function automatic void model_reset();
    m_stk.delete();
    m_mask = '1; m_all = 1; m_any = 0; m_ball = 1; m_bany = 0;
    m_ovf = 0; m_unf = 0; m_noact = 0; m_tag = "R10";
  endfunction

  function automatic void model_step(bit v, logic [1:0] op, logic [N-1:0] c, bit s);
    bit a = 1, o = 0;
    for (int k = 0; k < N; k++) if (m_mask[k]) begin
      a = a & c[k];
      o = o | c[k];
    end
    m_noact = (m_mask == '0);
    m_all = a; m_any = o; m_ball = a & s; m_bany = o & s;
    m_tag = "R11";
    if (v) begin
      case (op)
        2'd1: if (m_stk.size() == D) begin m_ovf = 1; m_tag = "R8"; end
              else begin m_stk.push_back(m_mask); m_mask = m_mask & c; m_tag = "R5"; end
        2'd2: if (m_stk.size() == 0) begin m_unf = 1; m_tag = "R9"; end
              else begin m_mask = m_stk[$] & ~c; m_tag = "R6"; end
        2'd3: if (m_stk.size() == 0) begin m_unf = 1; m_tag = "R9"; end
              else begin m_mask = m_stk.pop_back(); m_tag = "R7"; end
        default: ;
      endcase
    end
  endfunction

  task automatic chk(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk(m_noact ? "R3" : "R1", "all_o", N'(all_o), N'(m_all));
    chk(m_noact ? "R3" : "R2", "any_o", N'(any_o), N'(m_any));
    chk("R4", "br_all_o", N'(br_all_o), N'(m_ball));
    chk("R4", "br_any_o", N'(br_any_o), N'(m_bany));
    chk(m_tag, "mask_o", mask_o, m_mask);
    chk(m_tag, "depth_o", N'(depth_o), N'(m_stk.size()));
    chk("R8", "overflow_o", N'(overflow_o), N'(m_ovf));
    chk("R9", "underflow_o", N'(underflow_o), N'(m_unf));
  endtask

  task automatic cycle(bit v, logic [1:0] op, logic [N-1:0] c, bit s);
    @(negedge clk_i);
    check_all();
    op_valid_i = v; op_i = op; cond_i = c; scalar_cond_i = s;
    model_step(v, op, c, s);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0; op_valid_i = 0; op_i = 0; cond_i = '0; scalar_cond_i = 0;
    #1;
    model_reset();
    check_all(); // R10
    repeat (2) @(negedge clk_i);
    check_all(); // R10 held
    rst_ni = 1;
    model_step(0, 2'd0, cond_i, 0);
  endtask

  function automatic logic [N-1:0] rnd_vec();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  function automatic logic [N-1:0] pattern(int p);
    logic [N-1:0] r;
    case (p)
      0: r = rnd_vec();
      1: r = '1;
      2: r = '0;
      3: begin r = '1; r[$urandom_range(N-1)] = 1'b0; end
      default: begin r = '0; r[$urandom_range(N-1)] = 1'b1; end
    endcase
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // R1 R2 R4: flag reduction over all lanes; R11 invalid ops ignored
    for (int i = 0; i < 20; i++) cycle(0, 2'($urandom_range(3)), pattern(i % 5), 1'($urandom));
    for (int i = 0; i < 8; i++) cycle(1, 2'd0, pattern(i % 5), 1'($urandom));
    // R5 nest to full depth, each level drops one lane
    for (int i = 0; i < D; i++) cycle(1, 2'd1, pattern(3), 1'b1);
    for (int i = 0; i < 3; i++) cycle(0, 2'd0, pattern(1), 1'b1);
    cycle(1, 2'd1, pattern(0), 1'b1);            // R8 push while full
    cycle(1, 2'd2, pattern(4), 1'b1);            // R6 alternate at top
    for (int i = 0; i < D; i++) cycle(1, 2'd3, pattern(0), 1'($urandom)); // R7 drain
    cycle(1, 2'd3, pattern(0), 1'b1);            // R9 pop when empty
    cycle(0, 2'd0, pattern(0), 1'b1);
    do_reset();
    // R3 no lane active
    cycle(1, 2'd1, '0, 1'b1);
    for (int i = 0; i < 6; i++) cycle(0, 2'd0, pattern(i % 5), 1'b1);
    cycle(1, 2'd2, '0, 1'b1);                    // R6 mask returns to saved ones
    cycle(0, 2'd0, pattern(1), 1'b1);
    cycle(1, 2'd3, pattern(0), 1'b0);
    cycle(1, 2'd2, pattern(0), 1'b0);            // R9 alternate when empty
    cycle(0, 2'd0, pattern(0), 1'b0);
    do_reset();
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(9);
      logic [1:0] op = (r < 4) ? 2'd1 : (r < 6) ? 2'd2 : (r < 9) ? 2'd3 : 2'd0;
      cycle(($urandom_range(7) != 0), op, pattern($urandom_range(4)), 1'($urandom));
    end
    @(negedge clk_i);
    check_all();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule